// File: doc/BRIEF.md
# Fixed-Priority Writeback Port Arbiter

This block sits in front of one register-file write port. Several producers may present a result in the same cycle. The arbiter picks one of them by fixed priority and returns a per-producer ready. Request 0 always beats every other request, and the last request is the weakest.

The whole path is combinational. The chosen index, the chosen data, the grant vector, the output valid and the ready vector all follow the present inputs in the same cycle. A producer that can hold its result keeps it until its ready comes back high. A producer whose latency is fixed treats a low ready as a lost write.

When nothing is requesting, the selection rests on the last input. This keeps the data mux free of a separate idle case. The input count and the data width are parameters. The count must be at least one, and a single-input build grants that input unconditionally.

Top module: `wbarb_top`

## Requirements
- R1: When no bit of `req_valid` is set, `out_idx` equals N_REQ-1, `out_data` equals the data slice of input N_REQ-1, and `out_valid` is 0.
- R2: When at least one request is valid, `out_idx` is the smallest index whose valid bit is set, and `out_data` is that input's slice (`req_data[i*DATA_W +: DATA_W]`).
- R3: Bit 0 of `req_grant` equals `req_valid[0]`. Bit i>0 of `req_grant` is 1 exactly when none of `req_valid[i-1:0]` is set.
- R4: In a build with a single input, `req_grant` is 1 at all times.
- R5: For the input that is valid and granted, `req_ready` equals `out_ready`.
- R6: Every input whose valid bit is 0 sees its `req_ready` bit at 1, whatever `out_ready` is.
- R7: An input that is valid but not granted sees its `req_ready` bit at 0.
- R8: When the last grant bit is set, `out_valid` equals the last input's valid. Otherwise `out_valid` is 1. Taken together, `out_valid` is the OR of all valid bits.
- R9: Every output follows its inputs within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_valid | input | N_REQ | Request valid per producer, bit 0 highest priority |
| req_data | input | N_REQ*DATA_W | Producer data, input i at bits i*DATA_W upward |
| out_ready | input | 1 | Write port can accept this cycle |
| out_valid | output | 1 | A request is being forwarded |
| out_idx | output | IDX_W | Binary index of the chosen input |
| out_data | output | DATA_W | Data of the chosen input |
| req_grant | output | N_REQ | Priority grant vector |
| req_ready | output | N_REQ | Ready returned to each producer |

## Verification
On every clock edge the checker asserts the following facts about the ports:
- the resting choice when nothing is valid;
- that no valid request sits below the chosen index;
- that at most one valid input is granted;
- the ready rules for idle, winning and losing inputs;
- that `out_valid` matches any request.

Exact data routing, the full grant vector and the single-input build are shown only by the bench. The bench compares every output against a separately written model, over directed patterns and random valid, data and ready mixes. The same-cycle response is also shown only by the bench, which changes inputs between edges and reads the outputs before the next edge.

// File: rtl/wbarb_pkg.sv
package wbarb_pkg;

  // Index width; never zero so a single-input build still has a port.
  function automatic int unsigned idx_width(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // Mask with bits [k-1:0] set, used to ask "is anything above priority k valid".
  function automatic logic [63:0] low_mask(int unsigned k);
    logic [63:0] m;
    m = '0;
    for (int unsigned b = 0; b < 64; b++) m[b] = (b < k);
    return m;
  endfunction

endpackage

// File: rtl/wbarb_grant.sv
module wbarb_grant #(
  parameter int unsigned N_REQ = 4
) (
  input  logic [N_REQ-1:0] in_valid,
  output logic [N_REQ-1:0] grant,
  output logic             fwd_valid
);
  generate
    if (N_REQ == 1) begin : g_single
      // R4: lone input is always granted
      assign grant     = 1'b1;
      assign fwd_valid = in_valid[0];
    end else begin : g_chain
      // taken_above[i]: some request with index below i is valid
      logic [N_REQ-1:0] taken_above;
      for (genvar i = 0; i < N_REQ; i++) begin : g_bit
        if (i == 0) begin : g_head
          assign taken_above[0] = 1'b0;
          assign grant[0]       = in_valid[0];
        end else begin : g_tail
          assign taken_above[i] = taken_above[i-1] | in_valid[i-1];
          assign grant[i]       = ~taken_above[i];
        end
      end
      // R8: the last position qualifies on its own valid only
      assign fwd_valid = grant[N_REQ-1] ? in_valid[N_REQ-1] : 1'b1;
    end
  endgenerate
endmodule

// File: rtl/wbarb_select.sv
module wbarb_select #(
  parameter int unsigned N_REQ  = 4,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IDX_W  = 2
) (
  input  logic [N_REQ-1:0]        in_valid,
  input  logic [N_REQ*DATA_W-1:0] in_data,
  output logic [IDX_W-1:0]        sel_idx,
  output logic [DATA_W-1:0]       sel_data
);
  // Rest on the last input, then let each valid request, scanned from
  // weak to strong, override the choice: the smallest valid index remains.
  always_comb begin
    sel_idx  = IDX_W'(N_REQ - 1);
    sel_data = in_data[(N_REQ-1)*DATA_W +: DATA_W];
    for (int i = int'(N_REQ) - 2; i >= 0; i--) begin
      if (in_valid[i]) begin
        sel_idx  = IDX_W'(i);
        sel_data = in_data[i*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/wbarb_ready.sv
module wbarb_ready #(
  parameter int unsigned N_REQ = 4
) (
  input  logic [N_REQ-1:0] in_valid,
  input  logic [N_REQ-1:0] grant,
  input  logic             down_ready,
  output logic [N_REQ-1:0] up_ready
);
  // Idle producers are never held (R6); the winner follows the port (R5);
  // a valid loser is held off (R7).
  assign up_ready = ~in_valid | (grant & {N_REQ{down_ready}});
endmodule

// File: rtl/wbarb_top.sv
module wbarb_top #(
  parameter int unsigned N_REQ  = 4,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned IDX_W = wbarb_pkg::idx_width(N_REQ)
) (
  input  logic [N_REQ-1:0]        req_valid,
  input  logic [N_REQ*DATA_W-1:0] req_data,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic [IDX_W-1:0]        out_idx,
  output logic [DATA_W-1:0]       out_data,
  output logic [N_REQ-1:0]        req_grant,
  output logic [N_REQ-1:0]        req_ready
);
  logic [N_REQ-1:0] grant_w;
  logic             fwd_valid_w;

  wbarb_grant #(.N_REQ(N_REQ)) u_grant (
    .in_valid (req_valid),
    .grant    (grant_w),
    .fwd_valid(fwd_valid_w)
  );

  wbarb_select #(.N_REQ(N_REQ), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_select (
    .in_valid(req_valid),
    .in_data (req_data),
    .sel_idx (out_idx),
    .sel_data(out_data)
  );

  wbarb_ready #(.N_REQ(N_REQ)) u_ready (
    .in_valid  (req_valid),
    .grant     (grant_w),
    .down_ready(out_ready),
    .up_ready  (req_ready)
  );

  assign req_grant = grant_w;
  assign out_valid = fwd_valid_w;
endmodule

// Clocked port checker; the instantiating bench supplies clock and reset.
module wbarb_chk #(
  parameter int unsigned N_REQ  = 4,
  localparam int unsigned IDX_W = wbarb_pkg::idx_width(N_REQ)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_REQ-1:0] req_valid,
  input logic             out_ready,
  input logic             out_valid,
  input logic [IDX_W-1:0] out_idx,
  input logic [N_REQ-1:0] req_grant,
  input logic [N_REQ-1:0] req_ready
);
  logic [N_REQ-1:0] below_idx;
  logic [N_REQ-1:0] won_bit;
  assign below_idx = N_REQ'(wbarb_pkg::low_mask(int'(out_idx)));
  assign won_bit   = N_REQ'(1) << out_idx;

  a_r1_idle_rests_last: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid == '0) |-> (out_idx == IDX_W'(N_REQ-1) && !out_valid));
  a_r2_nothing_stronger: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid & below_idx) == '0);
  a_r3_single_valid_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_grant & req_valid));
  a_r5_winner_follows_port: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_valid & won_bit) != '0) |-> (((req_ready & won_bit) != '0) == out_ready));
  a_r6_idle_sees_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready | req_valid) == '1);
  a_r7_loser_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & req_valid & ~won_bit) == '0);
  a_r8_valid_iff_any: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == (req_valid != '0));
endmodule

// File: tb/wbarb_top_tb.sv
`timescale 1ns/1ps
module wbarb_top_tb;
  localparam int N = 4;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [N-1:0]   v;
  logic [N*W-1:0] d;
  logic           r;
  logic           ov;
  logic [1:0]     oi;
  logic [W-1:0]   od;
  logic [N-1:0]   og, ordy;

  logic [0:0]   s_v, s_g, s_rdy;
  logic [W-1:0] s_d, s_od;
  logic         s_r, s_ov;
  logic [0:0]   s_oi;

  wbarb_top #(.N_REQ(N), .DATA_W(W)) u_dut (
    .req_valid(v), .req_data(d), .out_ready(r), .out_valid(ov),
    .out_idx(oi), .out_data(od), .req_grant(og), .req_ready(ordy));

  wbarb_top #(.N_REQ(1), .DATA_W(W)) u_dut1 (
    .req_valid(s_v), .req_data(s_d), .out_ready(s_r), .out_valid(s_ov),
    .out_idx(s_oi), .out_data(s_od), .req_grant(s_g), .req_ready(s_rdy));

  wbarb_chk #(.N_REQ(N)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(v), .out_ready(r), .out_valid(ov),
    .out_idx(oi), .req_grant(og), .req_ready(ordy));

  typedef struct {
    logic [N-1:0] v;
    logic         ov;
    int           idx;
    logic [W-1:0] dat;
    logic [N-1:0] gnt;
    logic [N-1:0] rdy;
  } exp_t;

  exp_t sb[$];
  event ev_drv;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model written from the requirements, independent of the RTL.
  function automatic exp_t model(logic [N-1:0] vv, logic rr, logic [N*W-1:0] dd);
    exp_t e;
    e.v = vv;
    e.idx = N - 1;
    for (int i = N - 1; i >= 0; i--) if (vv[i]) e.idx = i;
    e.dat = dd[e.idx*W +: W];
    e.ov = |vv;
    for (int i = 0; i < N; i++) begin
      e.gnt[i] = (i == 0) ? vv[0] : ((vv & N'((1 << i) - 1)) == '0);
      e.rdy[i] = !vv[i] ? 1'b1 : ((i == e.idx) ? rr : 1'b0);
    end
    return e;
  endfunction

  task automatic apply(logic [N-1:0] vv, logic rr, logic [N*W-1:0] dd);
    @(negedge clk);
    v = vv; r = rr; d = dd;
    sb.push_back(model(vv, rr, dd));
    -> ev_drv;
  endtask

  // Monitor: pops each expected item and compares after inputs settle, mid-cycle.
  initial begin
    forever begin
      exp_t e;
      @(ev_drv);
      #1;
      e = sb.pop_front();
      if (e.v == '0) begin
        check(oi == 2'(e.idx), "R1 idx", oi, e.idx);
        check(od == e.dat, "R1 data", od, e.dat);
      end else begin
        check(oi == 2'(e.idx), "R2 idx", oi, e.idx);
        check(od == e.dat, "R2 data", od, e.dat);
      end
      check(og == e.gnt, "R3 grant", og, e.gnt);
      check(ov == e.ov, "R8 out_valid", ov, e.ov);
      for (int i = 0; i < N; i++) begin
        if (!e.v[i])              check(ordy[i] == e.rdy[i], "R6 ready", ordy[i], e.rdy[i]);
        else if (i == e.idx)      check(ordy[i] == e.rdy[i], "R5 ready", ordy[i], e.rdy[i]);
        else                      check(ordy[i] == e.rdy[i], "R7 ready", ordy[i], e.rdy[i]);
      end
    end
  end

  function automatic logic [N*W-1:0] pat(int seed);
    logic [N*W-1:0] x;
    for (int i = 0; i < N; i++) x[i*W +: W] = W'(16'h1000 * (i + 1) + seed);
    return x;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    v = '0; r = 1'b0; d = pat(5);
    s_v = 1'b0; s_d = 16'hBEEF; s_r = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state: nothing valid rests on the last input
    check(oi == 2'(N - 1), "R1 reset idx", oi, N - 1);
    check(ov == 1'b0, "R1 reset out_valid", ov, 0);
    check(od == d[(N-1)*W +: W], "R1 reset data", od, d[(N-1)*W +: W]);
    rst_n = 1'b1;

    apply('0, 1'b1, pat(1));
    for (int i = 0; i < N; i++) apply(N'(1) << i, 1'b1, pat(i + 2));
    apply(4'b1111, 1'b0, pat(9));
    apply(4'b1000, 1'b0, pat(10));
    apply(4'b1000, 1'b1, pat(11));
    apply(4'b0110, 1'b1, pat(12));
    apply(4'b1100, 1'b0, pat(13));
    apply('0, 1'b0, pat(14));

    // R9: only data changes; output follows before any clock edge
    @(negedge clk);
    v = 4'b0100; r = 1'b1; d = pat(20);
    #1;
    check(od == d[2*W +: W], "R9 same-cycle data", od, d[2*W +: W]);
    d[2*W +: W] = 16'h5A5A;
    #1;
    check(od == 16'h5A5A, "R9 same-cycle data change", od, 16'h5A5A);

    // R4: single-input build is always granted
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      s_v = k[0]; s_r = k[1]; s_d = 16'(k * 37 + 1);
      #1;
      check(s_g == 1'b1, "R4 grant", s_g, 1);
      check(s_ov == s_v, "R8 single valid", s_ov, s_v);
      check(s_od == s_d, "R2 single data", s_od, s_d);
      check(s_rdy == (s_v ? s_r : 1'b1), "R5 R6 single ready", s_rdy, (s_v ? s_r : 1'b1));
    end

    for (int k = 0; k < 400; k++) begin
      logic [N*W-1:0] rd;
      for (int j = 0; j < N; j++) rd[j*W +: W] = W'($urandom);
      apply(N'($urandom), 1'($urandom), rd);
    end

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule